// File: doc/BRIEF.md
# Wrap-Flag Ring Buffer Pointer Unit

This block keeps the read (head) and write (tail) positions of a ring buffer whose length is set at run time and may be any value from 1 to 1023 elements, not only a power of two. Each position is an 11-bit value. The low 10 bits are the element index and bit 10 is a wrap flag that toggles each time the index passes the end of the ring. Comparing the two wrap flags tells a completely full ring apart from an empty one without giving up a slot.

A producer requests a tail advance and gives an increment. A consumer requests a head advance and gives an increment. Both requests may arrive in the same cycle. The unit updates the pointers, reports the occupancy with full and empty flags, and rejects any request that would overrun or underrun the ring, raising a one-cycle error pulse. All amounts are counted in elements. The element storage, the bus interface and interrupts sit outside the block.

Top module: `ring_ptr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers become 0, wrap flags included, and both error pulses become 0. After reset the unit reports empty=1, full=0 and occupancy 0.
- R2: An accepted advance by N, where index+N stays below the size, gives the new pointer value pointer+N with the wrap flag (bit 10) unchanged. The new value is visible the cycle after the request.
- R3: An accepted advance by N, where index+N is greater than or equal to the size, gives the new index index+N−size, and the wrap flag (bit 10) is inverted.
- R4: When the wrap flags of head and tail differ, `occupancy` equals size − head index + tail index.
- R5: When the wrap flags are equal, `occupancy` equals tail − head. `empty` is 1 exactly when head and tail are identical in all 11 bits.
- R6: `full` is 1 when the ring is not empty and `occupancy` equals the latched size.
- R7: A tail advance that would make the occupancy exceed the size leaves the tail unchanged. `overflow_err` is then 1 for the one cycle after the request and 0 otherwise.
- R8: A head advance larger than the current occupancy leaves the head unchanged. `underflow_err` is then 1 for the one cycle after the request and 0 otherwise.
- R9: An advance request with an increment of 0 changes neither pointer and raises no error.
- R10: The size is taken from `cfg_size` only while the ring is empty. While the ring is not empty, a change on `cfg_size` has no effect on the wrap point or the overflow limit.
- R11: Head and tail requests in the same cycle are each judged against the occupancy before that cycle, and both are applied.
- R12: The largest size, 1023, works: a ring of that size can be filled in a single advance and then reports full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_size | input | 10 | Ring length in elements, latched while empty |
| tail_adv | input | 1 | Request to advance the tail |
| tail_inc | input | 10 | Tail increment in elements |
| head_adv | input | 1 | Request to advance the head |
| head_inc | input | 10 | Head increment in elements |
| head_ptr | output | 11 | Head: wrap flag in bit 10, index in bits 9..0 |
| tail_ptr | output | 11 | Tail: wrap flag in bit 10, index in bits 9..0 |
| occupancy | output | 11 | Number of elements held |
| full | output | 1 | Ring holds size elements |
| empty | output | 1 | Head equals tail |
| overflow_err | output | 1 | Tail request rejected in the previous cycle |
| underflow_err | output | 1 | Head request rejected in the previous cycle |

## Verification
The advance logic is tried with increments that stay short of the end and with increments that land exactly on it, so that a carry rule that is off by one shows up as a wrong wrap flag. Occupancy is read with equal wrap flags and with differing ones, and a completely full ring is read next to an empty one that has the same index. Both of these cases are meant to catch a comparison that ignores the flag. An overflow case is set up where only the latched size, and not the newly driven one, gives a rejection, which tells the size latch apart from a direct use of the input. Same-cycle head and tail requests, a one-step fill at the largest size, zero increments and underflow from an empty ring cover the remaining corners.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

    localparam int RP_DEF_IDX_W = 10;

    // outcome of one advance request
    typedef enum logic [1:0] {
        ADV_IDLE   = 2'd0,
        ADV_TAKE   = 2'd1,
        ADV_REJECT = 2'd2
    } adv_kind_e;

endpackage

// File: rtl/rp_advance.sv
module rp_advance #(
    parameter int IDX_W = 10,
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [IDX_W-1:0] inc,
    input  logic [IDX_W-1:0] size,
    output logic [PTR_W-1:0] nxt
);
    logic [IDX_W:0]   sum;
    logic [IDX_W-1:0] folded;

    always_comb begin
        sum    = {1'b0, ptr[IDX_W-1:0]} + {1'b0, inc};
        // exact modulo 2^IDX_W because the true result lies below size
        folded = ptr[IDX_W-1:0] + inc - size;
        if (sum >= {1'b0, size}) begin
            nxt = {~ptr[IDX_W], folded};
        end else begin
            nxt = {ptr[IDX_W], sum[IDX_W-1:0]};
        end
    end
endmodule

// File: rtl/rp_occupancy.sv
module rp_occupancy #(
    parameter int IDX_W = 10,
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [PTR_W-1:0] head,
    input  logic [PTR_W-1:0] tail,
    input  logic [IDX_W-1:0] size,
    output logic [IDX_W:0]   count,
    output logic             is_empty
);
    logic [IDX_W-1:0] same_lap;

    always_comb begin
        same_lap = tail[IDX_W-1:0] - head[IDX_W-1:0];
        if (head[IDX_W] != tail[IDX_W]) begin
            count = {1'b0, size} - {1'b0, head[IDX_W-1:0]} + {1'b0, tail[IDX_W-1:0]};
        end else begin
            count = {1'b0, same_lap};
        end
        is_empty = (head == tail);
    end
endmodule

// File: rtl/rp_gate.sv
module rp_gate
    import ring_ptr_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             req,
    input  logic [IDX_W-1:0] inc,
    input  logic [IDX_W:0]   room,
    output adv_kind_e        kind
);
    always_comb begin
        if (!req || inc == '0) begin
            kind = ADV_IDLE;
        end else if ({1'b0, inc} > room) begin
            kind = ADV_REJECT;
        end else begin
            kind = ADV_TAKE;
        end
    end
endmodule

// File: rtl/ring_ptr_unit.sv
module ring_ptr_unit
    import ring_ptr_pkg::*;
#(
    parameter int IDX_W = RP_DEF_IDX_W,
    localparam int PTR_W = IDX_W + 1,
    localparam int N_SIDE = 2   // 0: tail, 1: head
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] cfg_size,
    input  logic             tail_adv,
    input  logic [IDX_W-1:0] tail_inc,
    input  logic             head_adv,
    input  logic [IDX_W-1:0] head_inc,
    output logic [PTR_W-1:0] head_ptr,
    output logic [PTR_W-1:0] tail_ptr,
    output logic [IDX_W:0]   occupancy,
    output logic             full,
    output logic             empty,
    output logic             overflow_err,
    output logic             underflow_err
);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [IDX_W-1:0] size;
        logic             ovf;
        logic             unf;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] eff_size;
    logic [IDX_W:0]   count;
    logic             is_empty;

    logic      [N_SIDE-1:0]            side_req;
    logic      [N_SIDE-1:0][IDX_W-1:0] side_inc;
    logic      [N_SIDE-1:0][PTR_W-1:0] side_ptr;
    logic      [N_SIDE-1:0][PTR_W-1:0] side_nxt;
    logic      [N_SIDE-1:0][IDX_W:0]   side_room;
    adv_kind_e [N_SIDE-1:0]            side_kind;

    rp_occupancy #(.IDX_W(IDX_W)) u_occ (
        .head     (st_q.head),
        .tail     (st_q.tail),
        .size     (st_q.size),
        .count    (count),
        .is_empty (is_empty)
    );

    // size follows the input only while nothing is stored
    assign eff_size = is_empty ? cfg_size : st_q.size;

    assign side_req[0]  = tail_adv;
    assign side_inc[0]  = tail_inc;
    assign side_ptr[0]  = st_q.tail;
    assign side_room[0] = {1'b0, eff_size} - count;

    assign side_req[1]  = head_adv;
    assign side_inc[1]  = head_inc;
    assign side_ptr[1]  = st_q.head;
    assign side_room[1] = count;

    for (genvar g = 0; g < N_SIDE; g++) begin : g_side
        rp_advance #(.IDX_W(IDX_W)) u_adv (
            .ptr  (side_ptr[g]),
            .inc  (side_inc[g]),
            .size (eff_size),
            .nxt  (side_nxt[g])
        );
        rp_gate #(.IDX_W(IDX_W)) u_gate (
            .req  (side_req[g]),
            .inc  (side_inc[g]),
            .room (side_room[g]),
            .kind (side_kind[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.size = eff_size;
        st_d.ovf  = (side_kind[0] == ADV_REJECT);
        st_d.unf  = (side_kind[1] == ADV_REJECT);
        if (side_kind[0] == ADV_TAKE) begin
            st_d.tail = side_nxt[0];
        end
        if (side_kind[1] == ADV_TAKE) begin
            st_d.head = side_nxt[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_ptr      = st_q.head;
    assign tail_ptr      = st_q.tail;
    assign occupancy     = count;
    assign empty         = is_empty;
    assign full          = !is_empty && (count == {1'b0, st_q.size});
    assign overflow_err  = st_q.ovf;
    assign underflow_err = st_q.unf;

endmodule

// File: rtl/ring_ptr_chk.sv
module ring_ptr_chk #(
    parameter int IDX_W = 10,
    localparam int PTR_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             tail_adv,
    input logic [IDX_W-1:0] tail_inc,
    input logic             head_adv,
    input logic [IDX_W-1:0] head_inc,
    input logic [PTR_W-1:0] head_ptr,
    input logic [PTR_W-1:0] tail_ptr,
    input logic [IDX_W:0]   occupancy,
    input logic             full,
    input logic             empty,
    input logic             overflow_err,
    input logic             underflow_err
);
    // R1: the cycle after reset, both pointers are zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (head_ptr == '0 && tail_ptr == '0 && !overflow_err && !underflow_err));

    // R5: an empty ring holds nothing
    assert_empty_count_R5: assert property (@(posedge clk) disable iff (rst)
        empty |-> (occupancy == '0));

    // R6: full and empty never together
    assert_full_not_empty_R6: assert property (@(posedge clk) disable iff (rst)
        full |-> !empty);

    // R7: a rejected tail request leaves the tail where it was
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (overflow_err && !$past(rst)) |-> $stable(tail_ptr));

    // R8: a rejected head request leaves the head where it was
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        (underflow_err && !$past(rst)) |-> $stable(head_ptr));

    // R9: zero increments move nothing
    assert_zero_tail_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tail_adv) && $past(tail_inc) == '0) |-> ($stable(tail_ptr) && !overflow_err));

    assert_zero_head_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(head_adv) && $past(head_inc) == '0) |-> ($stable(head_ptr) && !underflow_err));
endmodule

bind ring_ptr_unit ring_ptr_chk #(.IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tail_adv      (tail_adv),
    .tail_inc      (tail_inc),
    .head_adv      (head_adv),
    .head_inc      (head_inc),
    .head_ptr      (head_ptr),
    .tail_ptr      (tail_ptr),
    .occupancy     (occupancy),
    .full          (full),
    .empty         (empty),
    .overflow_err  (overflow_err),
    .underflow_err (underflow_err)
);

// File: tb/tb_ring_ptr_unit.sv
module tb_ring_ptr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  cfg_size = 10'd5;
    logic        tail_adv = 1'b0;
    logic [9:0]  tail_inc = '0;
    logic        head_adv = 1'b0;
    logic [9:0]  head_inc = '0;
    logic [10:0] head_ptr, tail_ptr, occupancy;
    logic        full, empty, overflow_err, underflow_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ring_ptr_unit dut (
        .clk(clk), .rst(rst), .cfg_size(cfg_size),
        .tail_adv(tail_adv), .tail_inc(tail_inc),
        .head_adv(head_adv), .head_inc(head_inc),
        .head_ptr(head_ptr), .tail_ptr(tail_ptr), .occupancy(occupancy),
        .full(full), .empty(empty),
        .overflow_err(overflow_err), .underflow_err(underflow_err)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one request cycle; outputs are settled when the task returns
    task automatic op(bit ta, int ti, bit ha, int hi);
        @(negedge clk);
        tail_adv = ta; tail_inc = ti[9:0];
        head_adv = ha; head_inc = hi[9:0];
        @(negedge clk);
        tail_adv = 1'b0; tail_inc = '0;
        head_adv = 1'b0; head_inc = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 head", head_ptr, 0);
        chk("R1 tail", tail_ptr, 0);
        chk("R1 occupancy", occupancy, 0);
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 errors", {overflow_err, underflow_err}, 0);
    endtask

    task automatic t_basic();
        op(1, 3, 0, 0);
        chk("R2 tail after +3", tail_ptr, 11'h003);
        chk("R5 occupancy same lap", occupancy, 3);
        op(1, 2, 0, 0);
        chk("R3 tail wraps on exact end", tail_ptr, 11'h400);
        chk("R4 occupancy across wrap", occupancy, 5);
        chk("R6 full", full, 1);
        chk("R5 not empty when full", empty, 0);
        op(1, 1, 0, 0);
        chk("R7 overflow flag", overflow_err, 1);
        chk("R7 tail held", tail_ptr, 11'h400);
        op(0, 0, 0, 0);
        chk("R7 flag lasts one cycle", overflow_err, 0);
        op(0, 0, 1, 4);
        chk("R2 head after +4", head_ptr, 11'h004);
        chk("R4 occupancy 1", occupancy, 1);
        op(0, 0, 1, 2);
        chk("R8 underflow flag", underflow_err, 1);
        chk("R8 head held", head_ptr, 11'h004);
        op(0, 0, 1, 1);
        chk("R3 head wraps", head_ptr, 11'h400);
        chk("R5 empty after drain", empty, 1);
        chk("R8 flag cleared", underflow_err, 0);
        op(1, 0, 1, 0);
        chk("R9 tail unchanged", tail_ptr, 11'h400);
        chk("R9 head unchanged", head_ptr, 11'h400);
        chk("R9 no error", {overflow_err, underflow_err}, 0);
    endtask

    task automatic t_size_latch();
        op(1, 2, 0, 0);
        chk("R2 tail 0x402", tail_ptr, 11'h402);
        cfg_size = 10'd7;
        op(1, 4, 0, 0);
        chk("R10 old size still limits", overflow_err, 1);
        chk("R10 tail held", tail_ptr, 11'h402);
        op(0, 0, 1, 2);
        chk("R5 empty again", empty, 1);
        op(1, 6, 0, 0);
        chk("R10 new size wrap point", tail_ptr, 11'h001);
        chk("R10 occupancy with new size", occupancy, 6);
        chk("R10 no overflow", overflow_err, 0);
        op(1, 1, 1, 1);
        chk("R11 head", head_ptr, 11'h403);
        chk("R11 tail", tail_ptr, 11'h002);
        chk("R11 occupancy", occupancy, 6);
        chk("R11 no errors", {overflow_err, underflow_err}, 0);
        op(1, 1, 0, 0);
        chk("R6 full at 7", full, 1);
    endtask

    task automatic t_max();
        cfg_size = 10'd1023;
        do_reset();
        op(0, 0, 1, 1);
        chk("R8 underflow from empty", underflow_err, 1);
        chk("R8 head stays 0", head_ptr, 0);
        op(1, 1023, 0, 0);
        chk("R12 tail wraps", tail_ptr, 11'h400);
        chk("R12 occupancy", occupancy, 1023);
        chk("R12 full", full, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_size_latch();
        t_max();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule